// File: doc/BRIEF.md
# Vertical CCD Flush Controller

This block decides when the vertical register of a progressive-scan CCD is emptied by fast line transfers, and keeps a running count of how many lines have been moved. A falling edge on the active-low flush request, seen inside a short detection window that opens after each horizontal sync edge, arms the flush. The next horizontal sync edge starts it. While the flush runs, the block issues one transfer strobe per fixed-length transfer unit, and the vertical clock generator turns each strobe into one fast line shift.

When the request is released, the unit in progress always runs to its end, and the flush stops at that boundary. A saturating line counter adds up the flush strobes and the normal line transfers reported by the line sequencer. It raises an overflow flag when the line budget is reached and is cleared by each sensor readout pulse or each trigger falling edge. Vertical sync falling edges produce a readout request only while no flush is requested. Two or more distinct control falling edges inside one detection window raise an error pulse and cancel any arming of the flush.

Top module: `vflush_ctrl`

## Requirements
- R1: On a clock edge where `hd_i` is sampled high after being low and the flush is armed, `flush_active_o` and `xfer_stb_o` are both 1 in the following cycle.
- R2: While `flush_active_o` is 1, `xfer_stb_o` is a one-cycle pulse every UNIT_LEN (default 42) cycles, and the first pulse falls in the first active cycle.
- R3: When `efs_ni` rises during a transfer unit, that unit completes and `flush_active_o` falls right after it, so a flush lasts an exact multiple of UNIT_LEN cycles.
- R4: A falling edge of `efs_ni` is only counted while the detection window is open, which is for WIN_LEN (default 34) cycles after the edge that sampled the `hd_i` rise. A fall outside the window never starts a flush, even if `efs_ni` stays low through later windows.
- R5: A line counter adds one for each `xfer_stb_o` pulse and one for each cycle of `line_xfer_i`. It saturates at LINE_LIMIT (default 4096). `budget_ovf_o` is 1 exactly when the count has reached LINE_LIMIT, and stays 1 until a clear.
- R6: The count is cleared by `xsg_i` high, or by a falling edge of `trig_ni`, on the next clock edge. A clear takes priority over counting.
- R7: `vd_readout_o` pulses for one cycle after a falling edge of `vd_ni` is sampled, but only if `efs_ni` is high in that cycle.
- R8: If falling edges of two or more of `efs_ni`, `trig_ni` and `esg_ni` occur inside the same detection window, `edge_err_o` pulses the cycle after the second edge. The flush is disarmed, and no flush starts at the next HD edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Horizontal sync, active high, rising edge used |
| vd_ni | input | 1 | Vertical sync, active low |
| efs_ni | input | 1 | Flush request, active low |
| trig_ni | input | 1 | External trigger, active low |
| esg_ni | input | 1 | Exposure end request, active low |
| xsg_i | input | 1 | Sensor readout pulse, active high |
| line_xfer_i | input | 1 | Normal line transfer, one line per high cycle |
| flush_active_o | output | 1 | Flush in progress |
| xfer_stb_o | output | 1 | Start of one fast line transfer |
| budget_ovf_o | output | 1 | Line budget reached |
| edge_err_o | output | 1 | Conflicting control edges in one window |
| vd_readout_o | output | 1 | Readout request from vertical sync |

## Verification
Every result appears in the cycle after the clock edge that samples its cause. The inputs are registered only to detect edges, and each output comes straight from a register. The bench drives on the falling clock edge and samples on the next falling edge. So a check made one step after a stimulus sees the edge that acted on it: flush start, error pulse, readout pulse, counter clear and overflow. The unit boundaries are checked by stepping an exact number of cycles from the start and counting active cycles and strobes. Expected values are 42 cycles to the second strobe and 84 active cycles when the request is released in the second unit.

// File: rtl/vflush_pkg.sv
package vflush_pkg;
  localparam int unsigned N_SYNC   = 5;
  localparam int unsigned IDX_HD   = 0;
  localparam int unsigned IDX_VD   = 1;
  localparam int unsigned IDX_EFS  = 2;
  localparam int unsigned IDX_TRIG = 3;
  localparam int unsigned IDX_ESG  = 4;
  // idle levels: hd low, active-low controls high
  localparam logic [N_SYNC-1:0] SYNC_RST = 5'b11110;

  typedef struct packed {
    logic esg;
    logic trig;
    logic efs;
  } ctl_edges_t;
endpackage

// File: rtl/vflush_edge.sv
module vflush_edge #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= RST_VAL[g];
      else         q_o[g] <= sig_i[g];
    end
  end
endmodule

// File: rtl/vflush_window.sv
module vflush_window
  import vflush_pkg::*;
#(
  parameter int unsigned WIN_LEN = 34
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hd_rise_i,
  input  ctl_edges_t fall_i,
  input  logic       efs_rise_i,
  input  logic       active_i,
  input  logic       start_i,
  output logic       armed_o,
  output logic       err_o
);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam logic [WW-1:0] WIN_LOAD = WW'(WIN_LEN);

  logic [WW-1:0] win_cnt_q;
  ctl_edges_t    seen_q, seen_d, hits;
  logic          win_open, conflict, arm_set;

  assign win_open = (win_cnt_q != '0);
  assign hits     = win_open ? fall_i : '0;
  assign seen_d   = seen_q | hits;
  assign conflict = (hits != '0) && ($countones(seen_d) >= 2);
  assign arm_set  = hits.efs && !conflict && !active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      seen_q    <= '0;
    end else if (hd_rise_i) begin
      win_cnt_q <= WIN_LOAD;
      seen_q    <= '0;
    end else begin
      if (win_open) win_cnt_q <= win_cnt_q - 1'b1;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= conflict;
      if (conflict || efs_rise_i || start_i) armed_o <= 1'b0;
      else if (arm_set)                     armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vflush_unit_seq.sv
module vflush_unit_seq #(
  parameter int unsigned UNIT_LEN = 42
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic efs_rise_i,
  output logic active_o,
  output logic stb_o
);
  localparam int unsigned CW = $clog2(UNIT_LEN);
  localparam logic [CW-1:0] LAST = CW'(UNIT_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          stop_q, stop_now, unit_end;

  assign unit_end = active_o && (cnt_q == LAST);
  assign stop_now = stop_q || efs_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      stb_o    <= 1'b0;
      cnt_q    <= '0;
      stop_q   <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      stb_o    <= 1'b1;
      cnt_q    <= '0;
      stop_q   <= 1'b0;
    end else if (unit_end) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
      if (stop_now) begin
        active_o <= 1'b0;
        stb_o    <= 1'b0;
      end else begin
        stb_o <= 1'b1;
      end
    end else begin
      stb_o <= 1'b0;
      if (active_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (efs_rise_i) stop_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vflush_line_budget.sv
module vflush_line_budget #(
  parameter int unsigned LINE_LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flush_line_i,
  input  logic norm_line_i,
  output logic ovf_o
);
  localparam int unsigned CNT_W = $clog2(LINE_LIMIT) + 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LINE_LIMIT);

  logic [CNT_W-1:0] cnt_q, sum;

  assign sum   = cnt_q + CNT_W'(flush_line_i) + CNT_W'(norm_line_i);
  assign ovf_o = (cnt_q >= LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (sum >= LIM) cnt_q <= LIM;
    else                 cnt_q <= sum;
  end
endmodule

// File: rtl/vflush_ctrl.sv
module vflush_ctrl
  import vflush_pkg::*;
#(
  parameter int unsigned UNIT_LEN   = 42,
  parameter int unsigned WIN_LEN    = 34,
  parameter int unsigned LINE_LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_i,
  input  logic vd_ni,
  input  logic efs_ni,
  input  logic trig_ni,
  input  logic esg_ni,
  input  logic xsg_i,
  input  logic line_xfer_i,
  output logic flush_active_o,
  output logic xfer_stb_o,
  output logic budget_ovf_o,
  output logic edge_err_o,
  output logic vd_readout_o
);
  logic [N_SYNC-1:0] sig, sig_q;
  ctl_edges_t        falls;
  logic              hd_rise, vd_fall, efs_rise, trig_fall, armed, start;

  assign sig = {esg_ni, trig_ni, efs_ni, vd_ni, hd_i};

  vflush_edge #(.N(N_SYNC), .RST_VAL(SYNC_RST)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig), .q_o(sig_q)
  );

  assign hd_rise    = sig[IDX_HD] & ~sig_q[IDX_HD];
  assign vd_fall    = ~sig[IDX_VD] & sig_q[IDX_VD];
  assign efs_rise   = sig[IDX_EFS] & ~sig_q[IDX_EFS];
  assign trig_fall  = ~sig[IDX_TRIG] & sig_q[IDX_TRIG];
  assign falls.efs  = ~sig[IDX_EFS] & sig_q[IDX_EFS];
  assign falls.trig = trig_fall;
  assign falls.esg  = ~sig[IDX_ESG] & sig_q[IDX_ESG];
  assign start      = hd_rise & armed & ~flush_active_o;

  vflush_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .hd_rise_i(hd_rise), .fall_i(falls),
    .efs_rise_i(efs_rise), .active_i(flush_active_o), .start_i(start),
    .armed_o(armed), .err_o(edge_err_o)
  );

  vflush_unit_seq #(.UNIT_LEN(UNIT_LEN)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .efs_rise_i(efs_rise),
    .active_o(flush_active_o), .stb_o(xfer_stb_o)
  );

  vflush_line_budget #(.LINE_LIMIT(LINE_LIMIT)) u_budget (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(xsg_i | trig_fall),
    .flush_line_i(xfer_stb_o), .norm_line_i(line_xfer_i), .ovf_o(budget_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vd_readout_o <= 1'b0;
    else         vd_readout_o <= vd_fall & efs_ni;
  end
endmodule

// File: rtl/vflush_ctrl_chk.sv
module vflush_ctrl_chk #(
  parameter int unsigned UNIT_LEN = 42
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hd_i,
  input logic efs_ni,
  input logic trig_ni,
  input logic xsg_i,
  input logic flush_active_o,
  input logic xfer_stb_o,
  input logic budget_ovf_o,
  input logic vd_readout_o
);
  localparam int unsigned CW = $clog2(UNIT_LEN) + 2;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (xfer_stb_o) run_q <= CW'(1);
    else if (flush_active_o) run_q <= run_q + 1'b1;
  end

  AST_START_ON_HD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_active_o) |-> $past(hd_i)); // R1
  AST_START_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_active_o) |-> xfer_stb_o); // R2
  AST_STB_IN_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_stb_o |=> !xfer_stb_o); // R2
  AST_STOP_ON_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_active_o) |-> (run_q == CW'(UNIT_LEN))); // R3
  AST_OVF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (budget_ovf_o && !xsg_i && trig_ni) |=> budget_ovf_o); // R5
  AST_XSG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xsg_i |=> !budget_ovf_o); // R6
  AST_NO_READOUT_IN_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vd_readout_o |-> $past(efs_ni)); // R7
endmodule

bind vflush_ctrl vflush_ctrl_chk #(.UNIT_LEN(UNIT_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hd_i(hd_i), .efs_ni(efs_ni),
  .trig_ni(trig_ni), .xsg_i(xsg_i), .flush_active_o(flush_active_o),
  .xfer_stb_o(xfer_stb_o), .budget_ovf_o(budget_ovf_o),
  .vd_readout_o(vd_readout_o)
);

// File: tb/vflush_ctrl_tb.sv
`timescale 1ns/1ps
module vflush_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hd = 1'b0, vd_n = 1'b1, efs_n = 1'b1, trig_n = 1'b1, esg_n = 1'b1;
  logic xsg = 1'b0, line_xfer = 1'b0;
  logic act, stb, ovf, err, rdo;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  vflush_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .vd_ni(vd_n), .efs_ni(efs_n),
    .trig_ni(trig_n), .esg_ni(esg_n), .xsg_i(xsg), .line_xfer_i(line_xfer),
    .flush_active_o(act), .xfer_stb_o(stb), .budget_ovf_o(ovf),
    .edge_err_o(err), .vd_readout_o(rdo)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int actual, int expected);
    n_run++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic pulse_hd();
    hd = 1'b1; step(); hd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset active", act, 0);
    check("R2 reset strobe", stb, 0);
    check("R5 reset ovf", ovf, 0);
    check("R8 reset err", err, 0);
    check("R7 reset readout", rdo, 0);
  endtask

  task automatic t_flush();
    int n_act, n_stb;
    pulse_hd(); step(3);
    efs_n = 1'b0; step();
    check("R1 no start before HD", act, 0);
    step(5);
    pulse_hd();
    check("R1 active after HD", act, 1);
    check("R2 first strobe", stb, 1);
    n_act = 1; n_stb = 1;
    for (int i = 1; i <= 200; i++) begin
      if (i == 50) efs_n = 1'b1;
      step();
      if (i == 41) check("R2 no strobe mid unit", stb, 0);
      if (i == 42) check("R2 strobe after 42", stb, 1);
      if (act) n_act++;
      if (stb) n_stb++;
    end
    check("R3 active cycles", n_act, 84);
    check("R3 strobe count", n_stb, 2);
  endtask

  task automatic t_out_of_window();
    int n_act = 0;
    pulse_hd(); step(40);
    efs_n = 1'b0; step();
    for (int k = 0; k < 3; k++) begin
      pulse_hd();
      for (int i = 0; i < 50; i++) begin
        if (act) n_act++;
        step();
      end
    end
    check("R4 late fall ignored", n_act, 0);
    efs_n = 1'b1; step(2);
  endtask

  task automatic t_conflict();
    int n_act = 0;
    pulse_hd(); step(3);
    efs_n = 1'b0; step();
    check("R8 no err single edge", err, 0);
    step(2);
    trig_n = 1'b0; step();
    check("R8 err pulse", err, 1);
    step();
    check("R8 err one cycle", err, 0);
    pulse_hd();
    for (int i = 0; i < 60; i++) begin
      if (act) n_act++;
      step();
    end
    check("R8 flush cancelled", n_act, 0);
    efs_n = 1'b1; trig_n = 1'b1; step(3);
  endtask

  task automatic t_budget();
    xsg = 1'b1; step(); xsg = 1'b0;
    check("R6 xsg clear", ovf, 0);
    line_xfer = 1'b1; step(4095); line_xfer = 1'b0;
    check("R5 below limit", ovf, 0);
    line_xfer = 1'b1; step(); line_xfer = 1'b0;
    check("R5 at limit", ovf, 1);
    line_xfer = 1'b1; step(10); line_xfer = 1'b0; step(5);
    check("R5 saturated hold", ovf, 1);
    xsg = 1'b1; step(); xsg = 1'b0;
    check("R6 xsg clears ovf", ovf, 0);
    line_xfer = 1'b1; step(4096); line_xfer = 1'b0;
    check("R5 refill", ovf, 1);
    step(40);
    trig_n = 1'b0; step();
    check("R6 trig fall clears", ovf, 0);
    trig_n = 1'b1; step(2);
  endtask

  task automatic t_readout();
    vd_n = 1'b0; step();
    check("R7 readout with efs high", rdo, 1);
    vd_n = 1'b1; step();
    check("R7 readout one cycle", rdo, 0);
    step(40);
    efs_n = 1'b0; step(2);
    vd_n = 1'b0; step();
    check("R7 readout blocked", rdo, 0);
    vd_n = 1'b1; efs_n = 1'b1; step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_flush();
    t_out_of_window();
    t_conflict();
    t_budget();
    t_readout();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule